// File: doc/BRIEF.md
# Requester-ID to Stream-ID Hash Table

This block turns a 16-bit requester ID (bus, device and function) into a stream identifier for an address-translation unit. It holds 256 slots of 32 bits. The home slot of a requester ID is an 8-bit CRC of that ID. When two IDs land on the same home slot, the later one is placed in a following free slot and linked to the earlier entries through a pointer kept inside each slot. An insertion engine does the probing and the linking. A lookup engine walks the chain and answers hit or miss. A hit returns the stream ID. A plain write and clear port, plus a registered read port, let software build and inspect the table directly.

Insertion requests and lookup requests arrive on valid/ready channels. Lookup results leave on a valid/ready channel. Back-pressure rules:
- An insertion request is taken on a cycle where both `ins_valid` and `ins_ready` are high. `ins_ready` stays low until that insertion has finished.
- A lookup request is taken the same way. The result is then presented on `rsp_valid` and held with stable values until `rsp_ready` is seen high.
- No new request is taken while a result is waiting.
- Only one operation runs at a time. Direct writes and clears stall both engines.

Top module: `rid_sid_table`

## Requirements
- R1: The home slot of requester ID B is the CRC-8 of B, computed with generator 0x07 and initial value 0x00. B is fed most significant bit first, high byte before low byte. There is no reflection and no final XOR.
- R2: A slot holds the requester ID in bits [31:16], an 8-bit stream offset in bits [15:8] and the 8-bit index of the next slot in the chain in bits [7:0]. A slot whose 32 bits are all zero is empty. A next index of zero ends the chain.
- R3: Reset, or a one-cycle `tbl_clr` pulse, empties all 256 slots. It also discards the stream base.
- R4: An insertion starts at the home slot and steps forward one slot at a time, wrapping modulo 256, until it reaches an empty slot. Each occupied slot it passes whose next index is zero has its next index set to the slot that follows it. The new entry is written with next index zero.
- R5: The first insertion after reset or clear sets the stream base to its own stream ID. Every stored offset is (stream ID − base) mod 256.
- R6: A lookup starts at the home slot. It reports a miss on an empty slot. It reports a hit, with stream ID = base + offset, on a requester ID match. On a mismatch it follows the next index, or reports a miss if that index is zero.
- R7: A lookup that has visited 256 slots without a result reports a miss.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_hit` and `rsp_sid` hold their values. A miss reports `rsp_sid` = 0.
- R9: Operations are serialised. Both ready outputs are low while either engine is busy. When both requests are valid in the same cycle, the insertion is taken and the lookup waits.
- R10: While `tbl_wr_en` or `tbl_clr` is high, both ready outputs are low and neither engine advances. `tbl_wr_en` stores `tbl_wr_data` in slot `tbl_wr_idx`.
- R11: The engines visit one slot per cycle. A lookup that visits V slots raises `rsp_valid` V clock edges after the edge on which it was accepted. An insertion that probes P slots raises `ins_ready` again P edges after acceptance.
- R12: `tbl_rd_data` shows the slot addressed by `tbl_rd_idx` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_clr | input | 1 | Empty every slot and discard the base |
| tbl_wr_en | input | 1 | Direct slot write strobe |
| tbl_wr_idx | input | 8 | Direct write slot index |
| tbl_wr_data | input | 32 | Direct write slot value |
| tbl_rd_idx | input | 8 | Read port slot index |
| tbl_rd_data | output | 32 | Registered slot value |
| ins_valid | input | 1 | Insertion request valid |
| ins_ready | output | 1 | Insertion request accepted |
| ins_bdf | input | 16 | Requester ID to insert |
| ins_sid | input | SID_W | Stream ID to map it to |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_bdf | input | 16 | Requester ID to look up |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Lookup result consumed |
| rsp_hit | output | 1 | Result is a hit |
| rsp_sid | output | SID_W | Resolved stream ID, zero on miss |

## Verification
Every result has a fixed due cycle, so the bench counts clock edges from the accepting edge. A lookup answer is due after one edge per slot visited. The bench records the falling edge at which `rsp_valid` first appears and compares that count with the visit count it expects from the chain it built: 1 for a home-slot hit, 2 or 3 along a collision chain, 256 for a looped chain. Insertions are timed the same way against their probe counts. Read-port values are sampled one edge after the index is driven. All sampling happens on falling edges, between the rising edges that move the design.

// File: rtl/rid_sid_pkg.sv
package rid_sid_pkg;
  localparam int RID_W   = 16;
  localparam int IDX_W   = 8;
  localparam int OFF_W   = 8;
  localparam int SLOT_W  = RID_W + OFF_W + IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] CRC_POLY = 8'h07;

  typedef struct packed {
    logic [RID_W-1:0] rid;
    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] link;
  } slot_t;

  typedef enum logic [1:0] {LK_IDLE, LK_WALK, LK_RESP} lk_state_e;

  // bit-serial CRC, most significant bit of the ID first
  function automatic logic [IDX_W-1:0] home_slot(input logic [RID_W-1:0] rid);
    logic [IDX_W-1:0] c;
    c = '0;
    for (int i = RID_W - 1; i >= 0; i--) begin
      if (c[IDX_W-1] ^ rid[i]) c = {c[IDX_W-2:0], 1'b0} ^ CRC_POLY;
      else                     c = {c[IDX_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rid_slot_store.sv
module rid_slot_store
  import rid_sid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [SLOT_W-1:0] wdata,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [SLOT_W-1:0] eng_data,
  input  logic [IDX_W-1:0]  sw_idx,
  output logic [SLOT_W-1:0] sw_data
);
  logic [SLOT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign eng_data = mem[eng_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_data <= '0;
    else        sw_data <= mem[sw_idx];
  end
endmodule

// File: rtl/rid_insert_walk.sv
module rid_insert_walk
  import rid_sid_pkg::*;
#(
  parameter int SID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold,
  input  logic              blocked,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [RID_W-1:0]  ins_bdf,
  input  logic [SID_W-1:0]  ins_sid,
  output logic              busy,
  output logic [IDX_W-1:0]  probe_idx,
  input  logic [SLOT_W-1:0] probe_data,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output logic [SLOT_W-1:0] wdata,
  output logic [SID_W-1:0]  base
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST_PROBE = CNT_W'(ENTRIES - 1);

  logic             busy_q, base_ok_q;
  logic [IDX_W-1:0] idx_q;
  logic [RID_W-1:0] key_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SID_W-1:0] base_q;
  logic [SID_W-1:0] diff;
  slot_t            cur;
  logic             step, empty, fire;

  assign cur       = slot_t'(probe_data);
  assign empty     = (probe_data == '0);
  assign step      = busy_q && !hold;
  assign ins_ready = !busy_q && !blocked;
  assign fire      = ins_valid && ins_ready;
  assign busy      = busy_q;
  assign probe_idx = idx_q;
  assign base      = base_q;
  assign diff      = ins_sid - base_q;

  // write the new entry into an empty slot, or extend the chain past a tail
  assign we    = step && (empty || cur.link == '0);
  assign widx  = idx_q;
  assign wdata = empty ? {key_q, off_q, {IDX_W{1'b0}}}
                       : {cur.rid, cur.off, idx_q + 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; base_ok_q <= 1'b0; base_q <= '0;
      idx_q <= '0; key_q <= '0; off_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      busy_q <= 1'b0; base_ok_q <= 1'b0; base_q <= '0;
    end else if (fire) begin
      busy_q <= 1'b1;
      idx_q  <= home_slot(ins_bdf);
      key_q  <= ins_bdf;
      cnt_q  <= '0;
      if (base_ok_q) begin
        off_q <= diff[OFF_W-1:0];
      end else begin
        off_q     <= '0;
        base_q    <= ins_sid;
        base_ok_q <= 1'b1;
      end
    end else if (step) begin
      if (empty) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_PROBE) busy_q <= 1'b0;  // every slot taken: drop
      end
    end
  end
endmodule

// File: rtl/rid_lookup_walk.sv
module rid_lookup_walk
  import rid_sid_pkg::*;
#(
  parameter int SID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold,
  input  logic              blocked,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RID_W-1:0]  req_bdf,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [SID_W-1:0]  rsp_sid,
  output logic              busy,
  output logic [IDX_W-1:0]  walk_idx,
  input  logic [SLOT_W-1:0] walk_data,
  input  logic [SID_W-1:0]  base
);
  localparam int VIS_W = IDX_W + 1;
  localparam logic [VIS_W-1:0] LAST_VISIT = VIS_W'(ENTRIES - 1);

  lk_state_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic [RID_W-1:0] key_q;
  logic [VIS_W-1:0] vis_q;
  logic             hit_q;
  logic [SID_W-1:0] sid_q;
  slot_t            cur;

  assign cur       = slot_t'(walk_data);
  assign req_ready = (st_q == LK_IDLE) && !blocked;
  assign busy      = (st_q != LK_IDLE);
  assign walk_idx  = idx_q;
  assign rsp_valid = (st_q == LK_RESP);
  assign rsp_hit   = hit_q;
  assign rsp_sid   = sid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_IDLE; idx_q <= '0; key_q <= '0; vis_q <= '0;
      hit_q <= 1'b0; sid_q <= '0;
    end else begin
      case (st_q)
        LK_IDLE: if (req_valid && req_ready) begin
          st_q  <= LK_WALK;
          idx_q <= home_slot(req_bdf);
          key_q <= req_bdf;
          vis_q <= '0;
        end
        LK_WALK: if (!hold) begin
          if (walk_data == '0) begin
            st_q <= LK_RESP; hit_q <= 1'b0; sid_q <= '0;
          end else if (cur.rid == key_q) begin
            st_q <= LK_RESP; hit_q <= 1'b1;
            sid_q <= base + SID_W'(cur.off);
          end else if (cur.link == '0 || vis_q == LAST_VISIT) begin
            st_q <= LK_RESP; hit_q <= 1'b0; sid_q <= '0;
          end else begin
            idx_q <= cur.link;
            vis_q <= vis_q + 1'b1;
          end
        end
        LK_RESP: if (rsp_ready) st_q <= LK_IDLE;
        default: st_q <= LK_IDLE;
      endcase
      if (clr && st_q == LK_WALK) begin
        st_q <= LK_RESP; hit_q <= 1'b0; sid_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rid_sid_table.sv
module rid_sid_table
  import rid_sid_pkg::*;
#(
  parameter int SID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_clr,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [SLOT_W-1:0] tbl_wr_data,
  input  logic [IDX_W-1:0]  tbl_rd_idx,
  output logic [SLOT_W-1:0] tbl_rd_data,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [RID_W-1:0]  ins_bdf,
  input  logic [SID_W-1:0]  ins_sid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RID_W-1:0]  req_bdf,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [SID_W-1:0]  rsp_sid
);
  logic              hold, ins_busy, lk_busy, ins_fire;
  logic              ins_we;
  logic [IDX_W-1:0]  ins_widx, ins_pidx, lk_idx, eng_idx;
  logic [SLOT_W-1:0] ins_wdata, eng_data;
  logic [SID_W-1:0]  base;
  logic              st_we;
  logic [IDX_W-1:0]  st_widx;
  logic [SLOT_W-1:0] st_wdata;

  assign hold     = tbl_clr | tbl_wr_en;
  assign ins_fire = ins_valid & ins_ready;
  assign eng_idx  = ins_busy ? ins_pidx : lk_idx;
  assign st_we    = tbl_wr_en | ins_we;
  assign st_widx  = tbl_wr_en ? tbl_wr_idx  : ins_widx;
  assign st_wdata = tbl_wr_en ? tbl_wr_data : ins_wdata;

  rid_slot_store u_store (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .we(st_we), .widx(st_widx),
    .wdata(st_wdata), .eng_idx(eng_idx), .eng_data(eng_data),
    .sw_idx(tbl_rd_idx), .sw_data(tbl_rd_data)
  );

  rid_insert_walk #(.SID_W(SID_W)) u_ins (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .hold(hold),
    .blocked(hold | lk_busy), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_bdf(ins_bdf), .ins_sid(ins_sid), .busy(ins_busy),
    .probe_idx(ins_pidx), .probe_data(eng_data), .we(ins_we),
    .widx(ins_widx), .wdata(ins_wdata), .base(base)
  );

  rid_lookup_walk #(.SID_W(SID_W)) u_lk (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .hold(hold),
    .blocked(hold | ins_busy | ins_fire), .req_valid(req_valid),
    .req_ready(req_ready), .req_bdf(req_bdf), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_sid(rsp_sid),
    .busy(lk_busy), .walk_idx(lk_idx), .walk_data(eng_data), .base(base)
  );
endmodule

// File: rtl/rid_sid_table_chk.sv
module rid_sid_table_chk #(
  parameter int SID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_clr,
  input logic             tbl_wr_en,
  input logic [31:0]      tbl_rd_data,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [SID_W-1:0] rsp_sid
);
  a_r8_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_sid));

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_sid == '0);

  a_r9_one_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !ins_ready);

  a_r9_ins_first: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |-> !req_ready);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clr || tbl_wr_en |-> !req_ready && !ins_ready);

  a_r11_no_instant_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid);

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clr |=> ##1 tbl_rd_data == '0);
endmodule

bind rid_sid_table rid_sid_table_chk #(.SID_W(SID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_clr(tbl_clr), .tbl_wr_en(tbl_wr_en),
  .tbl_rd_data(tbl_rd_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_sid(rsp_sid)
);

// File: tb/rid_sid_table_test.sv
module rid_sid_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {bdf, hit, sid, visits}
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0100, 1'b1, 16'h0040, 9'd1},
    {16'h0208, 1'b1, 16'h0045, 9'd1},
    {16'h0007, 1'b1, 16'h004A, 9'd2},
    {16'h030E, 1'b1, 16'h007F, 9'd3},
    {16'h0209, 1'b0, 16'h0000, 9'd3},
    {16'h0000, 1'b0, 16'h0000, 9'd1},
    {16'h030F, 1'b0, 16'h0000, 9'd1}
  };

  logic clk = 0, rst_n = 0;
  logic tbl_clr = 0, tbl_wr_en = 0;
  logic [7:0] tbl_wr_idx = 0, tbl_rd_idx = 0;
  logic [31:0] tbl_wr_data = 0, tbl_rd_data;
  logic ins_valid = 0, ins_ready;
  logic [15:0] ins_bdf = 0, ins_sid = 0;
  logic req_valid = 0, req_ready;
  logic [15:0] req_bdf = 0;
  logic rsp_valid, rsp_ready = 0, rsp_hit;
  logic [15:0] rsp_sid;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rid_sid_table #(.SID_W(16)) uut (.*);

  function automatic logic [7:0] ref_hash(input logic [15:0] b);
    logic [23:0] r = {b, 8'h00};
    for (int i = 23; i >= 8; i--) if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_ins(input logic [15:0] b, input logic [15:0] s, output int probes);
    @(negedge clk);
    ins_valid = 1; ins_bdf = b; ins_sid = s;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_valid = 0;
    probes = 0;
    while (!ins_ready && probes < 400) begin @(negedge clk); probes++; end
  endtask

  task automatic do_look(input logic [15:0] b, input int stall,
                         output logic hit, output logic [15:0] sid, output int vis);
    @(negedge clk);
    req_valid = 1; req_bdf = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    vis = 0;
    while (!rsp_valid && vis < 400) begin @(negedge clk); vis++; end
    hit = rsp_hit; sid = rsp_sid;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R8 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R8 held sid", {16'd0, rsp_sid}, {16'd0, sid});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [31:0] v);
    @(negedge clk); tbl_rd_idx = i;
    @(negedge clk); v = tbl_rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, v;
    logic h;
    logic [15:0] s, key;
    logic [31:0] e;
    logic [7:0] h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset ins_ready", {31'd0, ins_ready}, 32'd1);
    chk("R3 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R3 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rd(8'h15, e);
    chk("R3 reset slot empty", e, 32'd0);

    // R4 R5 R11 build a chain of three on one home slot
    do_ins(16'h0100, 16'h0040, p); chk("R11 probes M0", p, 1);
    do_ins(16'h0208, 16'h0045, p); chk("R11 probes M1", p, 1);
    do_ins(16'h0007, 16'h004A, p); chk("R4 probes M2", p, 2);
    do_ins(16'h030E, 16'h007F, p); chk("R4 probes M3", p, 3);

    h0 = ref_hash(16'h0100);
    chk("R1 hash of 0100", {24'd0, h0}, 32'h15);
    rd(h0, e);            chk("R2 R12 head slot", e, {16'h0100, 8'h00, h0 + 8'd1});
    rd(h0 + 8'd1, e);     chk("R4 R5 second slot", e, {16'h0007, 8'h0A, h0 + 8'd2});
    rd(h0 + 8'd2, e);     chk("R4 tail next zero", e, {16'h030E, 8'h3F, 8'h00});
    rd(ref_hash(16'h0208), e); chk("R1 R2 M1 slot", e, {16'h0208, 8'h05, 8'h00});

    // R6 R11 table of lookups
    for (int n = 0; n < NVEC; n++) begin
      do_look(VEC[n][41:26], 0, h, s, v);
      chk($sformatf("R6 hit vec%0d", n), {31'd0, h}, {31'd0, VEC[n][25]});
      chk($sformatf("R6 R8 sid vec%0d", n), {16'd0, s}, {16'd0, VEC[n][24:9]});
      chk($sformatf("R11 visits vec%0d", n), v, {23'd0, VEC[n][8:0]});
    end

    // R8 back-pressure
    do_look(16'h0007, 3, h, s, v);
    chk("R8 bp hit", {31'd0, h}, 32'd1);

    // R9 insertion wins a tie
    @(negedge clk);
    ins_valid = 1; ins_bdf = 16'h0C00; ins_sid = 16'h0041;
    req_valid = 1; req_bdf = 16'h0100;
    #1;
    chk("R9 ins ready on tie", {31'd0, ins_ready}, 32'd1);
    chk("R9 req waits on tie", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    ins_valid = 0; req_valid = 0;
    repeat (8) @(negedge clk);
    do_look(16'h0C00, 0, h, s, v);
    chk("R9 tie insert landed", {15'd0, h, s}, {15'd0, 1'b1, 16'h0041});

    // R10 direct write stalls, R7 looped chain
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 8'h50; tbl_wr_data = {16'hABCD, 8'h00, 8'h50};
    req_valid = 1; req_bdf = 16'h0100;
    #1;
    chk("R10 req blocked", {31'd0, req_ready}, 32'd0);
    chk("R10 ins blocked", {31'd0, ins_ready}, 32'd0);
    @(negedge clk);
    tbl_wr_en = 0; req_valid = 0;
    rd(8'h50, e); chk("R10 direct write", e, {16'hABCD, 8'h00, 8'h50});
    key = 16'h0001;
    while (ref_hash(key) != 8'h50 || key == 16'hABCD) key++;
    do_look(key, 0, h, s, v);
    chk("R7 loop miss", {31'd0, h}, 32'd0);
    chk("R7 loop visits", v, 256);

    // R3 R5 clear then rebase
    @(negedge clk); tbl_clr = 1;
    @(negedge clk); tbl_clr = 0;
    rd(h0, e); chk("R3 cleared slot", e, 32'd0);
    do_look(16'h0100, 0, h, s, v);
    chk("R3 miss after clear", {31'd0, h}, 32'd0);
    chk("R3 miss visits", v, 1);
    do_ins(16'h0100, 16'h0200, p);
    do_look(16'h0100, 0, h, s, v);
    chk("R5 rebase sid", {15'd0, h, s}, {15'd0, 1'b1, 16'h0200});
    rd(h0, e); chk("R5 rebase offset", e, {16'h0100, 8'h00, 8'h00});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule